// File: doc/BRIEF.md
# Programmable Bus-Cycle Strobe Generator

This block times a single access to an asynchronous external memory device, such as a parallel disk interface or a flash array. Three 32-bit timing words sit at its inputs: one for reads, one for writes, and one general word. The surrounding register logic holds these words. A requester raises `req`, chooses the direction with `req_wr`, and keeps `req` high until `ack` pulses. The block then holds chip select low for the programmed number of bus clocks. It opens the read or write strobe inside a window that is placed with half-clock resolution, and it pulses a latch marker on the clock where read data is captured. After the access it waits out a programmed bus-release gap and then acknowledges.

Each strobe leaves the block as two bits per bus clock. Bit 0 is the level for the first half of the clock and bit 1 is the level for the second half, so the output stage can serialise them onto the pad. The start offset of the window counts forward from the beginning of the cycle. The stop offset and the capture point count backward from its end. An external wait input, whose polarity can be programmed, stretches the active cycle.

Top module: `bcs_strobe_gen`

## Requirements
- R1: While reset is asserted, and until the first request, `cs_n` is 1, both strobe pairs are 2'b11, and `latch` and `ack` are 0.
- R2: An accepted access holds `cs_n` low for C consecutive clocks when no wait is active. C is bits 31:24 of the direction's timing word, and a field value of 0 is treated as 1.
- R3: The active-low strobe covers half-clock phases p in the range A <= p < 2C-D. Phase p = 2k+h, where k is the clock index inside the cycle and h is the strobe bit (bit 0 is the first half). A is bits 11:8 of the timing word.
- R4: D, the stop offset in half-clock phases counted back from the end of the cycle, is bits 15:12 of the timing word.
- R5: When A+D >= 2C, the strobe stays high for the whole access.
- R6: A read (`req_wr`=0) takes its timing from `rd_word` and drives only `rd_strb_n`. A write takes its timing from `wr_word` and drives only `wr_strb_n`. The other pair stays 2'b11.
- R7: L is bits 23:20 of `gen_word`. On a read, `latch` is high on clock index C-L, on index C-1 when L=0, and on index 0 when L>=C. `rdata` takes `bus_din` at the clock edge that ends that index and holds it afterwards. Writes never raise `latch`.
- R8: After the last active clock, `cs_n` stays high for G idle clocks, where G is bits 14:11 of `gen_word`. Then `ack` is high for exactly one clock.
- R9: Bit 25 of `gen_word` set means `wait_in` is active low. When wait is active at a clock edge during the active cycle, the clock index does not advance, so every output repeats for one more clock.
- R10: The direction and all three words are sampled when the request is accepted. Changes during an access have no effect. A request still high through `ack` starts the next access only after one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 = write access, 0 = read |
| rd_word | input | 32 | Read timing word |
| wr_word | input | 32 | Write timing word |
| gen_word | input | 32 | Latch point, release gap and wait polarity |
| wait_in | input | 1 | External wait from the device |
| bus_din | input | DW | Data bus from the device |
| ack | output | 1 | One-clock completion pulse |
| cs_n | output | 1 | Active-low chip select |
| rd_strb_n | output | 2 | Read strobe, one bit per half clock |
| wr_strb_n | output | 2 | Write strobe, one bit per half clock |
| latch | output | 1 | Marks the read capture clock |
| rdata | output | DW | Captured read data |

## Verification
The bench replays the reference 12-clock read and checks odd phase offsets, which open or close the strobe in mid-clock. A design that confused the two halves, or that counted the stop offset forward, would shift the strobe edge by one phase. It programs windows with A+D equal to or beyond the cycle, a zero cycle field, and latch values of zero and beyond the cycle length. These catch a strobe that glitches, an access that never ends, and a capture clock that wraps to a wrong index. The bench changes `bus_din` right after the capture edge and scrambles the words in mid-access. A design that captured late or read the words live would then return the wrong data or timing. Stalls under both wait polarities, and a request held through `ack`, expose a counter that ignores wait and an access that restarts without the idle clock.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int CYC_W = 8;
  localparam int OFS_W = 4;
  localparam int GAP_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2,
    ST_ACK    = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic [CYC_W-1:0] cyc;      // clocks in the cycle, never 0
    logic [OFS_W-1:0] on_ph;    // phases from start to strobe on
    logic [OFS_W-1:0] off_ph;   // phases from strobe off to end
    logic [CYC_W-1:0] cap_idx;  // clock index of the capture
    logic [GAP_W-1:0] gap;      // idle clocks after the cycle
    logic             wait_lo;  // wait input active low
    logic             is_wr;    // write access
  } acc_cfg_t;
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
(
  input  logic        req_wr,
  input  logic [31:0] rd_word,
  input  logic [31:0] wr_word,
  input  logic [31:0] gen_word,
  output acc_cfg_t    cfg
);
  logic [31:0]      tword;
  logic [CYC_W-1:0] cyc_raw;
  logic [CYC_W-1:0] cyc_eff;
  logic [CYC_W-1:0] lat_ext;
  logic             unused_bits;

  assign tword   = req_wr ? wr_word : rd_word;
  assign cyc_raw = tword[31:24];
  assign cyc_eff = (cyc_raw == '0) ? CYC_W'(1) : cyc_raw;
  assign lat_ext = CYC_W'(gen_word[23:20]);

  always_comb begin
    cfg         = '0;
    cfg.cyc     = cyc_eff;
    cfg.on_ph   = tword[11:8];
    cfg.off_ph  = tword[15:12];
    cfg.gap     = gen_word[14:11];
    cfg.wait_lo = gen_word[25];
    cfg.is_wr   = req_wr;
    if (lat_ext == '0)          cfg.cap_idx = cyc_eff - CYC_W'(1);
    else if (lat_ext >= cyc_eff) cfg.cap_idx = '0;
    else                        cfg.cap_idx = cyc_eff - lat_ext;
  end

  assign unused_bits = ^{tword[23:16], tword[7:0], gen_word[31:26],
                         gen_word[24], gen_word[19:15], gen_word[10:0]};
endmodule

// File: rtl/bcs_phase_win.sv
module bcs_phase_win
  import bcs_pkg::*;
(
  input  acc_cfg_t         cfg,
  input  logic             active,
  input  logic [CYC_W-1:0] clk_idx,
  output logic [1:0]       strb_n
);
  localparam int PH_W = CYC_W + 2;

  logic [PH_W-1:0] end_ph;
  assign end_ph = {1'b0, cfg.cyc, 1'b0};

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [PH_W-1:0] ph;
    logic            open_w;
    assign ph     = {1'b0, clk_idx, 1'b0} + PH_W'(h);
    assign open_w = (ph >= PH_W'(cfg.on_ph)) &&
                    ((ph + PH_W'(cfg.off_ph)) < end_ph);
    assign strb_n[h] = ~(active & open_w);
  end
endmodule

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wait_in,
  input  acc_cfg_t         cfg_in,
  output acc_cfg_t         cfg_q,
  output logic             active,
  output logic [CYC_W-1:0] clk_idx,
  output logic             ack
);
  seq_st_t          st_q, st_d;
  logic [CYC_W-1:0] k_q, k_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             cfg_en;
  logic             wait_act;

  assign wait_act = wait_in ^ cfg_q.wait_lo;

  always_comb begin
    st_d   = st_q;
    k_d    = k_q;
    gap_d  = gap_q;
    cfg_en = 1'b0;
    case (st_q)
      ST_IDLE: if (req) begin
        st_d   = ST_ACTIVE;
        k_d    = '0;
        cfg_en = 1'b1;
      end
      ST_ACTIVE: if (!wait_act) begin
        if (k_q == cfg_q.cyc - CYC_W'(1)) begin
          if (cfg_q.gap == '0) st_d = ST_ACK;
          else begin
            st_d  = ST_GAP;
            gap_d = cfg_q.gap;
          end
        end else begin
          k_d = k_q + CYC_W'(1);
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_W'(1)) st_d = ST_ACK;
        else                    gap_d = gap_q - GAP_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      k_q   <= '0;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      k_q   <= k_d;
      gap_q <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_in;
  end

  assign active  = (st_q == ST_ACTIVE);
  assign clk_idx = k_q;
  assign ack     = (st_q == ST_ACK);

  assert_k_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (k_q < cfg_q.cyc));
  assert_gap_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> (gap_q != '0));
endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [31:0]   rd_word,
  input  logic [31:0]   wr_word,
  input  logic [31:0]   gen_word,
  input  logic          wait_in,
  input  logic [DW-1:0] bus_din,
  output logic          ack,
  output logic          cs_n,
  output logic [1:0]    rd_strb_n,
  output logic [1:0]    wr_strb_n,
  output logic          latch,
  output logic [DW-1:0] rdata
);
  logic             rst_i_n;
  acc_cfg_t         cfg_new;
  acc_cfg_t         cfg_q;
  logic             active;
  logic [CYC_W-1:0] clk_idx;
  logic [1:0]       win_n;
  logic             cap_en;

  bcs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  bcs_decode u_dec (
    .req_wr(req_wr), .rd_word(rd_word), .wr_word(wr_word),
    .gen_word(gen_word), .cfg(cfg_new)
  );

  bcs_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .req(req), .wait_in(wait_in),
    .cfg_in(cfg_new), .cfg_q(cfg_q), .active(active),
    .clk_idx(clk_idx), .ack(ack)
  );

  bcs_phase_win u_win (
    .cfg(cfg_q), .active(active), .clk_idx(clk_idx), .strb_n(win_n)
  );

  assign cs_n      = ~active;
  assign rd_strb_n = cfg_q.is_wr ? 2'b11 : win_n;
  assign wr_strb_n = cfg_q.is_wr ? win_n : 2'b11;
  assign cap_en    = active & ~cfg_q.is_wr & (clk_idx == cfg_q.cap_idx);
  assign latch     = cap_en;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    rdata <= '0;
    else if (cap_en) rdata <= bus_din;
  end

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack |=> !ack);
  assert_ack_after_cycle_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    ack |-> cs_n);
  assert_strb_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    cs_n |-> (rd_strb_n == 2'b11 && wr_strb_n == 2'b11));
  assert_one_direction_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_strb_n != 2'b11) |-> (wr_strb_n == 2'b11));
  assert_latch_on_read_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    latch |-> (!cs_n && wr_strb_n == 2'b11));
endmodule

// File: tb/tb_bcs_strobe_gen.sv
module tb_bcs_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  typedef struct {
    logic       cs_n;
    logic [1:0] rd_n;
    logic [1:0] wr_n;
    logic       lat;
    logic       ack;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, req_wr, wait_in;
  logic [31:0]   rd_word, wr_word, gen_word;
  logic [DW-1:0] bus_din;
  logic          ack, cs_n, latch;
  logic [1:0]    rd_strb_n, wr_strb_n;
  logic [DW-1:0] rdata;

  int   total = 0;
  int   bad = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcs_strobe_gen #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .rd_word(rd_word), .wr_word(wr_word), .gen_word(gen_word),
    .wait_in(wait_in), .bus_din(bus_din), .ack(ack), .cs_n(cs_n),
    .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n), .latch(latch),
    .rdata(rdata)
  );

  function automatic logic [31:0] tw(int c, int a, int d);
    return (32'(c) << 24) | (32'(d) << 12) | (32'(a) << 8);
  endfunction

  function automatic logic [31:0] gw(int l, int g, int pol);
    return (32'(pol) << 25) | (32'(l) << 20) | (32'(g) << 11);
  endfunction

  function automatic exp_t idle_item(string tag, logic a);
    exp_t e;
    e.cs_n = 1'b1; e.rd_n = 2'b11; e.wr_n = 2'b11;
    e.lat = 1'b0; e.ack = a; e.tag = tag;
    return e;
  endfunction

  // monitor: one comparison per expected item, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (cs_n !== e.cs_n || rd_strb_n !== e.rd_n || wr_strb_n !== e.wr_n ||
            latch !== e.lat || ack !== e.ack) begin
          bad++;
          $display("FAIL %s: cs/rd/wr/lat/ack got %b/%b/%b/%b/%b exp %b/%b/%b/%b/%b",
                   e.tag, cs_n, rd_strb_n, wr_strb_n, latch, ack,
                   e.cs_n, e.rd_n, e.wr_n, e.lat, e.ack);
        end
      end
    end
  end

  task automatic run_access(input string tag, input bit wr, input int c_f,
                            input int a, input int d, input int l, input int g,
                            input int pol, input int stall_at, input int stall_len,
                            input bit hold, input logic [DW-1:0] good);
    exp_t items[$];
    int   c, li, last_lat;
    c  = (c_f == 0) ? 1 : c_f;
    li = (l == 0) ? c - 1 : ((l >= c) ? 0 : c - l);
    last_lat = -1;
    for (int k = 0; k < c; k++) begin
      int reps;
      reps = (k == stall_at) ? stall_len + 1 : 1;
      for (int r = 0; r < reps; r++) begin
        exp_t e;
        logic [1:0] w;
        for (int h = 0; h < 2; h++) begin
          int p;
          p = 2*k + h;
          w[h] = !((p >= a) && (p + d < 2*c));
        end
        e.cs_n = 1'b0;
        e.rd_n = wr ? 2'b11 : w;
        e.wr_n = wr ? w : 2'b11;
        e.lat  = !wr && (k == li);
        e.ack  = 1'b0;
        e.tag  = tag;
        if (e.lat) last_lat = items.size();
        items.push_back(e);
      end
    end
    for (int i = 0; i < g; i++) items.push_back(idle_item(tag, 1'b0));
    items.push_back(idle_item(tag, 1'b1));

    @(negedge clk);
    req_wr   = wr;
    rd_word  = wr ? 32'hFFFF_FFFF : tw(c_f, a, d);
    wr_word  = wr ? tw(c_f, a, d) : 32'hFFFF_FFFF;
    gen_word = gw(l, g, pol);
    wait_in  = pol[0];
    bus_din  = good;
    req      = 1'b1;
    @(posedge clk);
    foreach (items[i]) sb_q.push_back(items[i]);
    #1;
    // R10: scramble direction and words after acceptance
    req_wr   = ~wr;
    rd_word  = 32'h0312_0000;
    wr_word  = 32'h0131_0000;
    gen_word = gw(15, 15, 1 - pol);
    for (int j = 0; j < items.size(); j++) begin
      @(negedge clk);
      wait_in = (stall_at >= 0 && j >= stall_at && j < stall_at + stall_len)
                ? ~pol[0] : pol[0];
      bus_din = (j <= last_lat) ? good : ~good;
    end
    wait_in = pol[0];
    if (hold) sb_q.push_back(idle_item({tag, "/R10 idle"}, 1'b0));
    else      req = 1'b0;
    if (!wr) begin
      total++;
      if (rdata !== good) begin
        bad++;
        $display("FAIL R7 (%s): rdata got %h exp %h", tag, rdata, good);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; wait_in = 1'b0;
    rd_word = '0; wr_word = '0; gen_word = '0; bus_din = '0;
    repeat (3) @(negedge clk);
    // R1: idle outputs during reset
    total++;
    if (cs_n !== 1'b1 || rd_strb_n !== 2'b11 || wr_strb_n !== 2'b11 ||
        latch !== 1'b0 || ack !== 1'b0) begin
      bad++;
      $display("FAIL R1: cs/rd/wr/lat/ack got %b/%b/%b/%b/%b exp 1/11/11/0/0",
               cs_n, rd_strb_n, wr_strb_n, latch, ack);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (cs_n !== 1'b1 || rd_strb_n !== 2'b11 || ack !== 1'b0) begin
      bad++;
      $display("FAIL R1: after release cs/rd/ack got %b/%b/%b exp 1/11/0",
               cs_n, rd_strb_n, ack);
    end

    // R2 R3 R4: reference read, 12 clocks, 7 and 6 phases, latch 2
    run_access("R3 ref read", 1'b0, 12, 7, 6, 2, 0, 0, -1, 0, 1'b0, 16'hA55A);
    // R6: write from its own word, different window
    run_access("R6 write", 1'b1, 5, 1, 3, 2, 0, 0, -1, 0, 1'b0, 16'h0000);
    // R4: odd stop offset in a read
    run_access("R4 read", 1'b0, 6, 2, 5, 3, 0, 0, -1, 0, 1'b0, 16'h1234);
    // R8: release gap of 3
    run_access("R8 gap", 1'b0, 4, 1, 1, 1, 3, 0, -1, 0, 1'b0, 16'h5A5A);
    // R5: window filled exactly, then overfilled
    run_access("R5 full", 1'b0, 3, 4, 2, 1, 0, 0, -1, 0, 1'b0, 16'h0F0F);
    run_access("R5 over", 1'b1, 2, 9, 9, 0, 1, 0, -1, 0, 1'b0, 16'h0);
    // R2: zero cycle field acts as one clock, latch 0 -> last clock
    run_access("R2 zero", 1'b0, 0, 0, 0, 0, 0, 0, -1, 0, 1'b0, 16'hBEEF);
    // R7: latch beyond cycle length -> clock 0
    run_access("R7 early", 1'b0, 5, 0, 0, 9, 0, 0, -1, 0, 1'b0, 16'hC3C3);
    // R9: wait stalls, active high then active low
    run_access("R9 hi", 1'b0, 8, 3, 2, 3, 1, 0, 2, 3, 1'b0, 16'h7E7E);
    run_access("R9 lo", 1'b1, 6, 1, 1, 1, 0, 1, 4, 2, 1'b0, 16'h0);
    run_access("R9 lat", 1'b0, 6, 0, 0, 2, 0, 1, 4, 2, 1'b0, 16'h3C3C);
    // R10: request held through ack, then back-to-back access
    run_access("R10 first", 1'b0, 3, 1, 1, 1, 0, 0, -1, 0, 1'b1, 16'h1111);
    run_access("R10 second", 1'b1, 3, 0, 1, 1, 2, 0, -1, 0, 1'b0, 16'h0);

    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule